// File: doc/BRIEF.md
# Parallel Multi-Lane LED String Waveform Generator

This block produces the single-wire, 800 kbit/s return-to-zero code used by chained RGB LED strings. It can drive up to sixteen strings at once from a 48 MHz clock. Every bit slot lasts 60 cycles and has three phases that all lanes share. The slot opens with every enabled lane high. Twelve cycles in, each lane takes the value of its own data bit. From cycle 31 every lane is low until the next slot begins. A short pulse therefore encodes a 0 and a long pulse encodes a 1. One lane can be driven in the same time as sixteen, because the lanes move together.

The pixel data comes from an external synchronous buffer that holds bit-planes. Each buffer word holds one bit for every lane, and word k is sent in slot k. Software lays out the buffer so that LED n, bit b (counted from the most significant bit of that LED's 24-bit colour word) sits at address n*24+b. The block issues one read per slot, at the first cycle of the slot, and uses the returned word in the data phase of the same slot. After the last slot the block holds every lane low for a reset guard of 2640 cycles (55 us). It then pulses `done` for one cycle and returns to idle.

The controller has three states. From IDLE, an accepted start moves to SEND if the LED count is nonzero, and to GUARD if the count is zero. SEND moves to GUARD at the end of the final slot. GUARD moves back to IDLE when its interval expires, and `done` is raised on that transition.

Top module: `led_lane_driver`

## Requirements
- R1: Out of reset, and whenever the block is idle, every lane output is low and `busy` and `done` are low.
- R2: A slot lasts 60 cycles. If `start` is sampled at clock edge E0, slot k opens on edge E0+1+60k, and every enabled lane is high for the first 12 cycles of the slot.
- R3: From slot cycle 12 to slot cycle 30, each enabled lane i equals bit i of the buffer word read for that slot.
- R4: From slot cycle 31 to slot cycle 59, every lane is low.
- R5: A lane whose bit in the enable mask is 0 stays low in every phase. The mask is captured when a start is accepted, and later changes to `lane_en` during a frame have no effect.
- R6: `rd_en` is high for exactly one cycle per slot, in the cycle after edge E0+60k, with `rd_addr` = k. Slots are sent in increasing address order.
- R7: A frame sends `led_count`*24 slots. A count above MAX_LEDS (60) is treated as MAX_LEDS, and a count of 0 sends no slots, only the guard.
- R8: After the last slot, all lanes stay low for 2640 guard cycles. `busy` is high from the accept edge up to edge E0+60N+2640, where N is the number of slots. `done` is high for exactly one cycle, the cycle after that edge, and `busy` is already low in that cycle.
- R9: A `start` pulse that arrives while `busy` is high is ignored, and the frame in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to send one frame; accepted only when idle |
| lane_en | input | LANES | Per-lane enable mask, captured at start |
| led_count | input | CNT_W | Number of LEDs in each string for this frame |
| rd_en | output | 1 | Read strobe to the bit-plane buffer |
| rd_addr | output | ADDR_W | Bit-plane word address (slot index) |
| rd_data | input | LANES | Buffer word, valid one cycle after rd_en |
| lanes_out | output | LANES | Data lines to the LED strings |
| busy | output | 1 | Frame or guard in progress |
| done | output | 1 | One-cycle pulse at the end of the guard |

## Verification
The assertions assume that the buffer returns its word exactly one cycle after `rd_en` and keeps that word stable until the next read. The bench memory model updates `rd_data` only on a read edge, so it stays within this assumption. The assertions also assume that `start` is only effective while idle. The stimulus therefore deliberately raises `start` and flips `lane_en` in the middle of a frame, so that the bench can confirm from the lane pins that neither disturbs the frame. Every input is changed on the falling edge, so the design samples settled values.

// File: rtl/led_lane_pkg.sv
package led_lane_pkg;

    localparam int BITS_PER_LED = 24;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_GUARD = 2'd2
    } drv_state_t;

endpackage

// File: rtl/slot_timer.sv
module slot_timer #(
    parameter int SLOT_CYC = 60,
    parameter int DATA_AT  = 12,
    parameter int LOW_AT   = 31,
    localparam int PHASE_W = $clog2(SLOT_CYC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    output logic [PHASE_W-1:0] phase,
    output logic               at_rise,
    output logic               at_capture,
    output logic               at_data,
    output logic               at_fall,
    output logic               at_last
);

    logic wrap;

    assign wrap = (phase == PHASE_W'(SLOT_CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (!run || wrap) begin
            phase <= '0;
        end else begin
            phase <= phase + PHASE_W'(1);
        end
    end

    always_comb begin
        at_rise    = run && (phase == '0);
        at_capture = run && (phase == PHASE_W'(1));
        at_data    = run && (phase == PHASE_W'(DATA_AT));
        at_fall    = run && (phase == PHASE_W'(LOW_AT));
        at_last    = run && wrap;
    end

endmodule

// File: rtl/slot_index.sv
module slot_index #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [ADDR_W-1:0] total,
    output logic [ADDR_W-1:0] idx,
    output logic              at_final
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clear) begin
            idx <= '0;
        end else if (advance) begin
            idx <= idx + ADDR_W'(1);
        end
    end

    assign at_final = (idx == total - ADDR_W'(1));

endmodule

// File: rtl/lane_cell.sv
module lane_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_val,
    input  logic go_high,
    input  logic go_data,
    input  logic go_low,
    output logic pin
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else if (go_high) begin
            pin <= enable;
        end else if (go_data) begin
            pin <= enable & bit_val;
        end else if (go_low) begin
            pin <= 1'b0;
        end
    end

endmodule

// File: rtl/led_lane_driver.sv
module led_lane_driver
    import led_lane_pkg::*;
#(
    parameter int LANES     = 16,
    parameter int MAX_LEDS  = 60,
    parameter int SLOT_CYC  = 60,
    parameter int DATA_AT   = 12,
    parameter int LOW_AT    = 31,
    parameter int GUARD_CYC = 2640,
    localparam int CNT_W    = $clog2(MAX_LEDS + 1),
    localparam int ADDR_W   = $clog2(MAX_LEDS * BITS_PER_LED + 1),
    localparam int PHASE_W  = $clog2(SLOT_CYC),
    localparam int GUARD_W  = $clog2(GUARD_CYC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LANES-1:0]  lane_en,
    input  logic [CNT_W-1:0]  led_count,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [LANES-1:0]  rd_data,
    output logic [LANES-1:0]  lanes_out,
    output logic              busy,
    output logic              done
);

    drv_state_t          state;
    drv_state_t          nxt;
    logic [LANES-1:0]    en_q;
    logic [LANES-1:0]    word_q;
    logic [ADDR_W-1:0]   total_q;
    logic [ADDR_W-1:0]   want_total;
    logic [ADDR_W-1:0]   slot_idx;
    logic [CNT_W-1:0]    cnt_eff;
    logic [GUARD_W-1:0]  guard_cnt;
    logic [PHASE_W-1:0]  phase;
    logic                done_q;
    logic                accept;
    logic                sending;
    logic                guard_end;
    logic                ph_rise, ph_cap, ph_data, ph_fall, ph_last;
    logic                slot_final;

    assign accept    = (state == ST_IDLE) && start;
    assign sending   = (state == ST_SEND);
    assign guard_end = (guard_cnt == GUARD_W'(GUARD_CYC - 1));

    // Count clamp and slot total for the frame being accepted.
    always_comb begin
        cnt_eff    = (led_count > CNT_W'(MAX_LEDS)) ? CNT_W'(MAX_LEDS) : led_count;
        want_total = ADDR_W'(cnt_eff) * ADDR_W'(BITS_PER_LED);
    end

    slot_timer #(
        .SLOT_CYC (SLOT_CYC),
        .DATA_AT  (DATA_AT),
        .LOW_AT   (LOW_AT)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (sending),
        .phase      (phase),
        .at_rise    (ph_rise),
        .at_capture (ph_cap),
        .at_data    (ph_data),
        .at_fall    (ph_fall),
        .at_last    (ph_last)
    );

    slot_index #(
        .ADDR_W (ADDR_W)
    ) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .advance  (ph_last),
        .total    (total_q),
        .idx      (slot_idx),
        .at_final (slot_final)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lane_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .enable  (en_q[i]),
            .bit_val (word_q[i]),
            .go_high (ph_rise),
            .go_data (ph_data),
            .go_low  (ph_fall),
            .pin     (lanes_out[i])
        );
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state decision.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    nxt = (cnt_eff == '0) ? ST_GUARD : ST_SEND;
                end
            end
            ST_SEND: begin
                if (ph_last && slot_final) begin
                    nxt = ST_GUARD;
                end
            end
            ST_GUARD: begin
                if (guard_end) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs and per-state working registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= '0;
            total_q   <= '0;
            word_q    <= '0;
            guard_cnt <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    guard_cnt <= '0;
                    if (start) begin
                        en_q    <= lane_en;
                        total_q <= want_total;
                    end
                end
                ST_SEND: begin
                    guard_cnt <= '0;
                    if (ph_cap) begin
                        word_q <= rd_data;
                    end
                end
                ST_GUARD: begin
                    guard_cnt <= guard_cnt + GUARD_W'(1);
                    if (guard_end) begin
                        done_q <= 1'b1;
                    end
                end
                default: guard_cnt <= '0;
            endcase
        end
    end

    assign rd_en   = ph_rise;
    assign rd_addr = slot_idx;
    assign busy    = (state != ST_IDLE);
    assign done    = done_q;

endmodule

// File: rtl/led_lane_checker.sv
module led_lane_checker
    import led_lane_pkg::*;
#(
    parameter int LANES   = 16,
    parameter int PHASE_W = 6,
    parameter int LOW_AT  = 31
) (
    input logic               clk,
    input logic               rst_n,
    input drv_state_t         state,
    input logic [PHASE_W-1:0] phase,
    input logic [LANES-1:0]   en_q,
    input logic [LANES-1:0]   lanes_out,
    input logic               rd_en,
    input logic               busy,
    input logic               done
);

    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (lanes_out == '0));

    p_slot_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && phase == PHASE_W'(1)) |-> (lanes_out == en_q));

    p_slot_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && phase == PHASE_W'(LOW_AT + 1)) |-> (lanes_out == '0));

    p_mask_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((lanes_out & ~en_q) == '0));

    p_single_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

    p_guard_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GUARD) |-> (lanes_out == '0));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(busy));

endmodule

bind led_lane_driver led_lane_checker #(
    .LANES   (LANES),
    .PHASE_W (PHASE_W),
    .LOW_AT  (LOW_AT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .phase     (phase),
    .en_q      (en_q),
    .lanes_out (lanes_out),
    .rd_en     (rd_en),
    .busy      (busy),
    .done      (done)
);

// File: tb/led_lane_driver_bench.sv
module led_lane_driver_bench;

    localparam int LANES  = 16;
    localparam int MAXL   = 60;
    localparam int SLOT   = 60;
    localparam int GUARD  = 2640;
    localparam int CNT_W  = $clog2(MAXL + 1);
    localparam int ADDR_W = $clog2(MAXL * 24 + 1);
    localparam int WORDS  = MAXL * 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [LANES-1:0]  lane_en = '0;
    logic [CNT_W-1:0]  led_count = '0;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [LANES-1:0]  rd_data = '0;
    logic [LANES-1:0]  lanes_out;
    logic              busy;
    logic              done;

    logic [LANES-1:0]  mem [WORDS];

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    led_lane_driver u_led_lane_driver (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .lane_en   (lane_en),
        .led_count (led_count),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .lanes_out (lanes_out),
        .busy      (busy),
        .done      (done)
    );

    // Synchronous buffer model: word appears one cycle after the read.
    always @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
        cycles <= cycles + 1;
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cycles > 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, got %0d cycles exp < 190000", cycles);
            summary();
        end
    end

    task automatic fill(input int seed);
        for (int i = 0; i < WORDS; i++) begin
            mem[i] = LANES'((i * 40503 + seed * 977) ^ (i << 5) ^ (seed << 9));
        end
    endtask

    // label names the requirement this frame targets.
    task automatic run_frame(input int cnt, input logic [LANES-1:0] en,
                             input int seed, input string label,
                             input bit poke_start, input bit poke_en);
        int n;
        int tot;
        int k;
        int p;
        string tag;
        logic [LANES-1:0] ex_out;
        bit ex_busy, ex_done, ex_rd;
        fill(seed);
        n   = ((cnt > MAXL) ? MAXL : cnt) * 24;
        tot = SLOT * n + GUARD;
        @(negedge clk);
        start     = 1'b1;
        lane_en   = en;
        led_count = CNT_W'(cnt);
        @(negedge clk);
        start = 1'b0;
        for (int m = 0; m <= tot; m++) begin
            if (m > 0) @(negedge clk);
            ex_out = '0;
            tag = "R8";
            if (m >= 1 && m <= SLOT * n) begin
                k = (m - 1) / SLOT;
                p = (m - 1) % SLOT;
                if (p < 12) begin
                    ex_out = en;
                    tag = "R2";
                end else if (p < 31) begin
                    ex_out = en & mem[k];
                    tag = "R3";
                end else begin
                    tag = "R4";
                end
            end
            ex_busy = (m <= tot - 1);
            ex_done = (m == tot);
            ex_rd   = (m < SLOT * n) && (m % SLOT == 0);
            checks++;
            if (lanes_out !== ex_out) begin
                errors++;
                $display("FAIL %s/%s lanes m=%0d got %h exp %h", tag, label, m, lanes_out, ex_out);
            end
            if (busy !== ex_busy || done !== ex_done) begin
                errors++;
                $display("FAIL R8/%s busy,done m=%0d got %b%b exp %b%b", label, m, busy, done, ex_busy, ex_done);
            end
            if (rd_en !== ex_rd || (ex_rd && rd_addr !== ADDR_W'(m / SLOT))) begin
                errors++;
                $display("FAIL R6/%s read m=%0d got %b@%0d exp %b@%0d", label, m, rd_en, rd_addr, ex_rd, m / SLOT);
            end
            if (poke_start && m == 100) start = 1'b1;
            if (poke_start && m == 101) start = 1'b0;
            if (poke_start && m == tot - 2) start = 1'b1;
            if (poke_start && m == tot - 1) start = 1'b0;
            if (poke_en && m == 70) lane_en = ~en;
        end
        @(negedge clk);
        checks++;
        if (lanes_out !== '0 || busy !== 1'b0 || done !== 1'b0) begin
            errors++;
            $display("FAIL R1/%s idle after frame got %h %b %b exp 0 0 0", label, lanes_out, busy, done);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        checks++;
        if (lanes_out !== '0 || busy !== 1'b0 || done !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset state got %h %b %b exp 0 0 0", lanes_out, busy, done);
        end
        rst_n = 1'b1;
        @(negedge clk);
        run_frame(1, 16'hFFFF, 1, "R3", 1'b0, 1'b0);
        run_frame(2, 16'h00F3, 2, "R5", 1'b0, 1'b1);
        run_frame(0, 16'hFFFF, 3, "R7", 1'b0, 1'b0);
        run_frame(3, 16'hA5C3, 4, "R9", 1'b1, 1'b0);
        run_frame(63, 16'h8001, 5, "R7", 1'b0, 1'b0);
        summary();
    end

endmodule